// File: doc/BRIEF.md
# Clock-Synchronous Serial Receiver with Overrun Lockout

This block receives 8-bit frames from a single serial data line and hands each finished frame to a host through a small register-style interface. It runs in one of two clocking modes. As clock master, it produces its own transfer clock by dividing the system clock. As clock slave, it follows a transfer clock that another device drives in. In both modes the data line is sampled on the rising edge of the transfer clock, and the least significant bit arrives first.

A finished frame is copied into a holding register and a full flag is raised. When the host reads the frame, it pulses a read strobe, and that pulse clears the full flag. A frame can finish while the previous one is still unread. In that case the new frame is discarded, a sticky overrun flag is raised, and reception stops until the host writes a clear. The receive interrupt follows the full flag, gated by an enable. The error interrupt follows the overrun flag.

The control logic is a three-state machine:
- `ST_OFF`: receive disabled.
- `ST_SHIFT`: receiving bits.
- `ST_STOPPED`: overrun lockout.

Its transitions are:
- OFF→SHIFT when `rx_en` rises.
- SHIFT→OFF when `rx_en` falls. This aborts the partial frame.
- SHIFT→STOPPED when a frame completes while full.
- STOPPED→SHIFT when the overrun is cleared with `rx_en` high.
- STOPPED→OFF when the overrun is cleared with `rx_en` low.

Top module: `serial_rx_unit`

## Requirements
- R1: After reset, `rx_full`, `ovr_flag`, `rx_irq`, `err_irq` are 0, `rd_data` is 0 and `sclk_out` is 1.
- R2: In slave mode (`cfg_master`=0), `sclk_in` and `sdata_in` pass through two-flop synchronizers. Each rising edge of `sclk_in` samples one bit, with bit 0 first. After the eighth bit, `rd_data` holds the frame and `rx_full` is 1.
- R3: In master mode (`cfg_master`=1), `sclk_out` idles at 1. While receiving, it toggles every max(`cfg_half_div`,1) system clocks, giving a period of 2·max(`cfg_half_div`,1). Each rising edge samples `sdata_in` as the next bit, with bit 0 first.
- R4: While `rx_en` is 0, incoming frames are ignored and `sclk_out` stays 1.
- R5: A one-cycle `rd_strobe` clears `rx_full`.
- R6: `rx_irq` equals `rx_full` AND `irq_en`.
- R7: If `rx_full` is still 1 when the eighth rising edge arrives, the frame is discarded. In that case `rd_data` keeps its value, `ovr_flag` becomes 1 and `err_irq` becomes 1.
- R8: While `ovr_flag` is 1, no frame is taken and `sclk_out` stays 1. A one-cycle `ovr_clr` pulse clears the flag, and reception then resumes.
- R9: Dropping `rx_en` in mid-frame discards the partial bits and restarts the bit count. `rx_full` and `ovr_flag` are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_master | input | 1 | 1: generate the transfer clock, 0: follow `sclk_in` |
| cfg_half_div | input | DIV_W | Half-period of the master clock in system clocks (0 is treated as 1) |
| rx_en | input | 1 | Receive enable |
| irq_en | input | 1 | Receive interrupt enable |
| sclk_in | input | 1 | Transfer clock from the remote master |
| sdata_in | input | 1 | Serial data line |
| rd_strobe | input | 1 | Host read of the frame register, clears the full flag |
| ovr_clr | input | 1 | Host write that clears the overrun flag |
| sclk_out | output | 1 | Transfer clock driven in master mode |
| rd_data | output | FRAME_W | Last accepted frame |
| rx_full | output | 1 | Frame waiting to be read |
| ovr_flag | output | 1 | Sticky overrun error |
| rx_irq | output | 1 | Receive interrupt |
| err_irq | output | 1 | Overrun interrupt |

## Verification
The bench mixes frame patterns across both clocking modes, and each pattern would expose a bit-order or stored-value error. It lets a second frame arrive before the first is read. A receiver that judged the overrun too late, or stored the late frame anyway, would show the wrong `rd_data` or no error. While the lockout is in force, it reads the frame and sends another. A design that kept receiving would set `rx_full` again or keep its master clock running. It also aborts a half-received frame by dropping the enable, and checks the divider period at the zero and odd half-period settings. A leftover bit count would misalign the next frame, and a divider error would change the measured period.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

    typedef enum logic [1:0] {
        ST_OFF     = 2'd0,
        ST_SHIFT   = 2'd1,
        ST_STOPPED = 2'd2
    } rx_state_t;

endpackage

// File: rtl/srx_master_clk.sv
module srx_master_clk #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half_div,
    output logic             sclk_o,
    output logic             rise_tick
);

    logic [DIV_W-1:0] cnt_q;
    logic             sclk_q;
    logic [DIV_W-1:0] limit;
    logic             at_limit;

    // A zero setting behaves as the fastest legal divisor.
    assign limit    = (half_div == '0) ? DIV_W'(0) : half_div - DIV_W'(1);
    assign at_limit = (cnt_q == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            sclk_q <= 1'b1;
        end else if (!run) begin
            cnt_q  <= '0;
            sclk_q <= 1'b1;
        end else if (at_limit) begin
            cnt_q  <= '0;
            sclk_q <= ~sclk_q;
        end else begin
            cnt_q <= cnt_q + DIV_W'(1);
        end
    end

    assign sclk_o    = sclk_q;
    assign rise_tick = run && at_limit && !sclk_q;

    // R4 / R8: clock parks high one cycle after it is stopped
    a_r4_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> sclk_q);

endmodule

// File: rtl/srx_slave_sync.sv
module srx_slave_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_in,
    input  logic sdata_in,
    output logic rise_tick,
    output logic data_o
);

    logic [STAGES-1:0] ck_sr;
    logic [STAGES-1:0] dt_sr;
    logic              ck_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ck_sr   <= '1;
            dt_sr   <= '0;
            ck_prev <= 1'b1;
        end else begin
            ck_sr   <= {ck_sr[STAGES-2:0], sclk_in};
            dt_sr   <= {dt_sr[STAGES-2:0], sdata_in};
            ck_prev <= ck_sr[STAGES-1];
        end
    end

    assign rise_tick = ck_sr[STAGES-1] && !ck_prev;
    assign data_o    = dt_sr[STAGES-1];

endmodule

// File: rtl/srx_frame_fsm.sv
module srx_frame_fsm
    import serial_rx_pkg::*;
#(
    parameter int FRAME_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rx_en,
    input  logic               tick,
    input  logic               bit_in,
    input  logic               rd_strobe,
    input  logic               ovr_clr,
    output logic [FRAME_W-1:0] data_o,
    output logic               full_o,
    output logic               ovr_o,
    output logic               shifting_o
);

    localparam int CNT_W = $clog2(FRAME_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_W - 1);

    rx_state_t          state_q, state_d;
    logic [CNT_W-1:0]   cnt_q;
    logic [FRAME_W-1:0] shreg_q;
    logic [FRAME_W-1:0] data_q;
    logic               full_q;
    logic               ovr_q;
    logic               frame_done;
    logic               store_c;
    logic               overrun_c;

    assign frame_done = (state_q == ST_SHIFT) && rx_en && tick && (cnt_q == LAST_BIT);
    assign store_c    = frame_done && !full_q;
    assign overrun_c  = frame_done && full_q;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (rx_en) state_d = ST_SHIFT;
            end
            ST_SHIFT: begin
                if (!rx_en)         state_d = ST_OFF;
                else if (overrun_c) state_d = ST_STOPPED;
            end
            ST_STOPPED: begin
                if (ovr_clr) state_d = rx_en ? ST_SHIFT : ST_OFF;
            end
            default: state_d = ST_OFF;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // Datapath and flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            shreg_q <= '0;
            data_q  <= '0;
            full_q  <= 1'b0;
            ovr_q   <= 1'b0;
        end else begin
            if (state_d != ST_SHIFT || state_q != ST_SHIFT) begin
                cnt_q <= '0;
            end else if (tick) begin
                shreg_q <= {bit_in, shreg_q[FRAME_W-1:1]};
                cnt_q   <= (cnt_q == LAST_BIT) ? '0 : cnt_q + CNT_W'(1);
            end

            if (store_c) begin
                data_q <= {bit_in, shreg_q[FRAME_W-1:1]};
                full_q <= 1'b1;
            end else if (rd_strobe) begin
                full_q <= 1'b0;
            end

            if (overrun_c)    ovr_q <= 1'b1;
            else if (ovr_clr) ovr_q <= 1'b0;
        end
    end

    assign data_o     = data_q;
    assign full_o     = full_q;
    assign ovr_o      = ovr_q;
    assign shifting_o = (state_q == ST_SHIFT);

    // R7: overrun only arises on top of an unread frame
    a_r7_ovr_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr_q) |-> $past(full_q));

    // R8: held frame is frozen during the lockout
    a_r8_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_q && $past(ovr_q)) |-> $stable(data_q));

    // R8: lockout state and error flag agree
    a_r8_state_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STOPPED) == ovr_q);

    // R5: a read without a simultaneous store empties the register
    a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && !store_c) |=> !full_q);

    // R2: the frame register only changes when it was empty
    a_r2_store_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(data_q) |-> !$past(full_q));

endmodule

// File: rtl/serial_rx_unit.sv
module serial_rx_unit #(
    parameter int FRAME_W     = 8,
    parameter int DIV_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_master,
    input  logic [DIV_W-1:0]   cfg_half_div,
    input  logic               rx_en,
    input  logic               irq_en,
    input  logic               sclk_in,
    input  logic               sdata_in,
    input  logic               rd_strobe,
    input  logic               ovr_clr,
    output logic               sclk_out,
    output logic [FRAME_W-1:0] rd_data,
    output logic               rx_full,
    output logic               ovr_flag,
    output logic               rx_irq,
    output logic               err_irq
);

    logic m_tick, m_sclk;
    logic s_tick, s_data;
    logic shifting;
    logic run_master;
    logic tick;
    logic bit_in;

    assign run_master = cfg_master && shifting;

    srx_master_clk #(.DIV_W(DIV_W)) u_mclk (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run_master),
        .half_div  (cfg_half_div),
        .sclk_o    (m_sclk),
        .rise_tick (m_tick)
    );

    srx_slave_sync #(.STAGES(SYNC_STAGES)) u_ssync (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_in   (sclk_in),
        .sdata_in  (sdata_in),
        .rise_tick (s_tick),
        .data_o    (s_data)
    );

    assign tick   = cfg_master ? m_tick   : s_tick;
    assign bit_in = cfg_master ? sdata_in : s_data;

    srx_frame_fsm #(.FRAME_W(FRAME_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_en      (rx_en),
        .tick       (tick),
        .bit_in     (bit_in),
        .rd_strobe  (rd_strobe),
        .ovr_clr    (ovr_clr),
        .data_o     (rd_data),
        .full_o     (rx_full),
        .ovr_o      (ovr_flag),
        .shifting_o (shifting)
    );

    assign sclk_out = cfg_master ? m_sclk : 1'b1;
    assign rx_irq   = rx_full && irq_en;
    assign err_irq  = ovr_flag;

    // R6: receive interrupt never fires without its enable and a frame
    a_r6_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |-> (irq_en && rx_full));

endmodule

// File: tb/test_serial_rx_unit.sv
module test_serial_rx_unit;

    localparam int CLK_P = 10;
    localparam int HALF  = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_master = 1'b0;
    logic [7:0] cfg_half_div = 8'd2;
    logic       rx_en = 1'b0, irq_en = 1'b1;
    logic       sclk_in = 1'b1, sdata_in = 1'b0;
    logic       rd_strobe = 1'b0, ovr_clr = 1'b0;
    logic       sclk_out, rx_full, ovr_flag, rx_irq, err_irq;
    logic [7:0] rd_data;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_P/2) clk = ~clk;

    serial_rx_unit i_serial_rx_unit (
        .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_half_div(cfg_half_div),
        .rx_en(rx_en), .irq_en(irq_en), .sclk_in(sclk_in), .sdata_in(sdata_in),
        .rd_strobe(rd_strobe), .ovr_clr(ovr_clr), .sclk_out(sclk_out), .rd_data(rd_data),
        .rx_full(rx_full), .ovr_flag(ovr_flag), .rx_irq(rx_irq), .err_irq(err_irq)
    );

    // {master, frame}
    localparam logic [8:0] VEC [6] = '{9'h0A5, 9'h001, 9'h180, 9'h15A, 9'h0FF, 9'h100};

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_slave(input logic [7:0] b, input int nbits);
        for (int i = 0; i < nbits; i++) begin
            sclk_in  = 1'b0;
            sdata_in = b[i];
            repeat (HALF) @(negedge clk);
            sclk_in = 1'b1;
            repeat (HALF) @(negedge clk);
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic send_master(input logic [7:0] b);
        for (int i = 0; i < 8; i++) begin
            while (sclk_out !== 1'b0) @(negedge clk);
            sdata_in = b[i];
            while (sclk_out !== 1'b1) @(negedge clk);
        end
    endtask

    task automatic pulse_rd();
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
    endtask

    task automatic measure_period(input logic [7:0] h, input int exp, input string req);
        int n = 0;
        cfg_master = 1'b1;
        cfg_half_div = h;
        rx_en = 1'b1;
        while (sclk_out !== 1'b0) @(negedge clk);
        while (sclk_out !== 1'b1) @(negedge clk);
        while (sclk_out !== 1'b0) begin @(negedge clk); n++; end
        while (sclk_out !== 1'b1) begin @(negedge clk); n++; end
        chk(req, n, exp);
        rx_en = 1'b0;
        repeat (3) @(negedge clk);
        cfg_master = 1'b0;
    endtask

    initial begin
        #(CLK_P * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 full", int'(rx_full), 0);
        chk("R1 ovr", int'(ovr_flag), 0);
        chk("R1 irq", int'({rx_irq, err_irq}), 0);
        chk("R1 data", int'(rd_data), 0);
        chk("R1 sclk", int'(sclk_out), 1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // Vector walk: R2 slave frames, R3 master frames, R5 read clear, R6 irq
        foreach (VEC[k]) begin
            cfg_master = VEC[k][8];
            cfg_half_div = 8'd2;
            rx_en = 1'b1;
            @(negedge clk);
            if (VEC[k][8]) send_master(VEC[k][7:0]);
            else           send_slave(VEC[k][7:0], 8);
            chk(VEC[k][8] ? "R3 data" : "R2 data", int'(rd_data), int'(VEC[k][7:0]));
            chk("R2 full", int'(rx_full), 1);
            chk("R6 irq on", int'(rx_irq), 1);
            rx_en = 1'b0;
            pulse_rd();
            chk("R5 cleared", int'(rx_full), 0);
            repeat (3) @(negedge clk);
            cfg_master = 1'b0;
        end

        // R6 enable gating
        irq_en = 1'b0;
        rx_en = 1'b1;
        send_slave(8'h3C, 8);
        chk("R6 masked", int'(rx_irq), 0);
        irq_en = 1'b1;
        @(negedge clk);
        chk("R6 unmasked", int'(rx_irq), 1);

        // R7 overrun
        send_slave(8'hA5, 8);
        chk("R7 ovr", int'(ovr_flag), 1);
        chk("R7 err_irq", int'(err_irq), 1);
        chk("R7 kept data", int'(rd_data), 8'h3C);

        // R8 lockout
        pulse_rd();
        send_slave(8'h11, 8);
        chk("R8 no rx", int'(rx_full), 0);
        chk("R8 data", int'(rd_data), 8'h3C);
        cfg_master = 1'b1;
        repeat (20) @(negedge clk);
        chk("R8 sclk held", int'(sclk_out), 1);
        cfg_master = 1'b0;
        ovr_clr = 1'b1;
        @(negedge clk);
        ovr_clr = 1'b0;
        chk("R8 cleared", int'(ovr_flag), 0);
        send_slave(8'h77, 8);
        chk("R8 resumed", int'(rd_data), 8'h77);
        pulse_rd();

        // R9 abort
        send_slave(8'hFF, 4);
        rx_en = 1'b0;
        repeat (3) @(negedge clk);
        chk("R9 flags kept", int'({rx_full, ovr_flag}), 0);
        rx_en = 1'b1;
        @(negedge clk);
        send_slave(8'h81, 8);
        chk("R9 realigned", int'(rd_data), 8'h81);
        pulse_rd();

        // R4 disabled
        rx_en = 1'b0;
        send_slave(8'h42, 8);
        chk("R4 ignored", int'(rx_full), 0);
        chk("R4 data", int'(rd_data), 8'h81);
        cfg_master = 1'b1;
        repeat (20) @(negedge clk);
        chk("R4 sclk idle", int'(sclk_out), 1);
        cfg_master = 1'b0;

        // R3 divider periods
        measure_period(8'd3, 6, "R3 div6");
        measure_period(8'd1, 2, "R3 div2");
        measure_period(8'd0, 2, "R3 div0");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule